// File: doc/BRIEF.md
# Two-Level Interrupt Gate

This block collects interrupt events from a framer's transmit section, its receive section and a once-per-second timer, and presents one level-active interrupt line to a CPU. Each event first latches into a status bit. It then has to pass two gates before it reaches the CPU. The first gate is a per-section master enable in a block-level register. The second is a per-source enable. A master enable that is 0 silences its whole section, whatever the source enables hold.

The CPU reaches the registers through an 8-bit address and data port with single-cycle read and write strobes. Read data is registered and appears on the cycle after the read strobe. Status bits set on their event pulses whatever the enables hold, so software can poll them. A read clears them.

The receive section arrives as one request line that its own source logic has already gated. This block applies only the receive master enable to it.

Top module: `irq_two_level`

## Requirements
- R1: After reset, every enable and status bit is 0, `irqOut` is 0, and reads of 0x04, 0x34 and 0x05 return 0x00.
- R2: Register 0x04 holds three writable enables: bit 7 for receive, bit 1 for transmit and bit 0 for one-second. Bits 6 to 2 always read 0, so writing 0xFF reads back as 0x83.
- R3: A one-cycle `txDoneEvt` pulse sets the transmit status, bit 0 of 0x34, whatever the enables hold.
- R4: A read of 0x34 returns the status as it stood before the read, then clears it. The next read returns bit 0 as 0.
- R5: If `txDoneEvt` pulses in the same cycle as a read of 0x34, that read returns the old status and the status bit is left set.
- R6: Bit 1 of 0x34 is the read/write transmit source enable. Bits 7 to 2 read 0, and a write cannot change status bit 0, so writing 0xFF reads back as 0x02 when no event is pending.
- R7: The transmit status drives `irqOut` only while both 0x04 bit 1 and 0x34 bit 1 are 1. With all of 0x04 at 0, `irqOut` is 0.
- R8: `rxReq` drives `irqOut` only while 0x04 bit 7 is 1.
- R9: A `secEvt` pulse sets bit 0 of 0x05, whatever the enables hold. A read of 0x05 clears it. It drives `irqOut` only while 0x04 bit 0 is 1.
- R10: Reads of any other address return 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Register address |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe, one cycle per access |
| rdEn | input | 1 | Read strobe, one cycle per access |
| rdData | output | 8 | Read data, valid the cycle after `rdEn` |
| txDoneEvt | input | 1 | Pulse: transmit message complete |
| secEvt | input | 1 | Pulse: one-second tick |
| rxReq | input | 1 | Receive section request, already gated at source level |
| irqOut | output | 1 | Interrupt to CPU, active high |

## Verification
The assertions assume that `wrEn` and `rdEn` are never high together. They also assume the event inputs are clean one-cycle pulses that are synchronous to `clk`.

The bench drives every strobe and pulse for exactly one cycle, from the falling edge. It never issues a read and a write in the same cycle. The only deliberate overlap is an event that coincides with a status read, and the bench creates it to exercise R5.

// File: rtl/irq_two_level_pkg.sv
package irq_two_level_pkg;
  parameter int ADDR_W = 8;
  parameter int DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_BLK   = 8'h04;
  localparam logic [ADDR_W-1:0] ADDR_TXSRC = 8'h34;
  localparam logic [ADDR_W-1:0] ADDR_SEC   = 8'h05;

  localparam int BIT_RX_EN  = 7;
  localparam int BIT_TX_EN  = 1;
  localparam int BIT_SEC_EN = 0;
  localparam int BIT_SRC_EN = 1;
  localparam int BIT_STAT   = 0;

  localparam logic [DATA_W-1:0] BLK_MASK =
    DATA_W'((1 << BIT_RX_EN) | (1 << BIT_TX_EN) | (1 << BIT_SEC_EN));
  localparam logic [DATA_W-1:0] SRC_MASK = DATA_W'(1 << BIT_SRC_EN);

  typedef struct packed {
    logic wrBlk;
    logic wrTxSrc;
    logic rdAny;
    logic rdBlk;
    logic rdTxSrc;
    logic rdSec;
  } strobeT;
endpackage

// File: rtl/irq_reg_ctrl.sv
module irq_reg_ctrl
  import irq_two_level_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output strobeT            stb
);
  logic hitBlk, hitTx, hitSec;

  always_comb begin
    hitBlk      = (addr == ADDR_BLK);
    hitTx       = (addr == ADDR_TXSRC);
    hitSec      = (addr == ADDR_SEC);
    stb.wrBlk   = wrEn & hitBlk;
    stb.wrTxSrc = wrEn & hitTx;
    stb.rdAny   = rdEn;
    stb.rdBlk   = rdEn & hitBlk;
    stb.rdTxSrc = rdEn & hitTx;
    stb.rdSec   = rdEn & hitSec;
  end
endmodule

// File: rtl/irq_reg_datapath.sv
module irq_reg_datapath
  import irq_two_level_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              txDoneEvt,
  input  logic              secEvt,
  input  logic              rxReq,
  output logic [DATA_W-1:0] blkEn,
  output logic [DATA_W-1:0] txCfg,
  output logic              txStat,
  output logic              secStat,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  logic [DATA_W-1:0] rdMux;
  logic txPend, rxPend, secPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blkEn   <= '0;
      txCfg   <= '0;
      txStat  <= 1'b0;
      secStat <= 1'b0;
      rdData  <= '0;
    end else begin
      if (stb.wrBlk)   blkEn <= wrData & BLK_MASK;
      if (stb.wrTxSrc) txCfg <= wrData & SRC_MASK;
      // an event in the same cycle as the clearing read wins
      txStat  <= txDoneEvt | (txStat & ~stb.rdTxSrc);
      secStat <= secEvt | (secStat & ~stb.rdSec);
      if (stb.rdAny) rdData <= rdMux;
    end
  end

  always_comb begin
    rdMux = '0;
    if (stb.rdBlk) rdMux = blkEn;
    if (stb.rdTxSrc) begin
      rdMux = txCfg;
      rdMux[BIT_STAT] = txStat;
    end
    if (stb.rdSec) rdMux[BIT_STAT] = secStat;
  end

  always_comb begin
    txPend  = blkEn[BIT_TX_EN] & txCfg[BIT_SRC_EN] & txStat;
    rxPend  = blkEn[BIT_RX_EN] & rxReq;
    secPend = blkEn[BIT_SEC_EN] & secStat;
    irqOut  = txPend | rxPend | secPend;
  end
endmodule

// File: rtl/irq_two_level.sv
module irq_two_level
  import irq_two_level_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  input  logic              txDoneEvt,
  input  logic              secEvt,
  input  logic              rxReq,
  output logic              irqOut
);
  strobeT            stb;
  logic [DATA_W-1:0] blkEn;
  logic [DATA_W-1:0] txCfg;
  logic              txStat;
  logic              secStat;

  irq_reg_ctrl i_ctrl (
    .addr (addr),
    .wrEn (wrEn),
    .rdEn (rdEn),
    .stb  (stb)
  );

  irq_reg_datapath i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (wrData),
    .txDoneEvt (txDoneEvt),
    .secEvt    (secEvt),
    .rxReq     (rxReq),
    .blkEn     (blkEn),
    .txCfg     (txCfg),
    .txStat    (txStat),
    .secStat   (secStat),
    .rdData    (rdData),
    .irqOut    (irqOut)
  );
endmodule

// File: rtl/irq_two_level_chk.sv
module irq_two_level_chk
  import irq_two_level_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              rdEn,
  input logic [DATA_W-1:0] rdData,
  input logic              txDoneEvt,
  input logic              secEvt,
  input logic              rxReq,
  input logic              irqOut,
  input logic [DATA_W-1:0] blkEn,
  input logic              txStat,
  input logic              secStat
);
  AST_TX_SETS: assert property (@(posedge clk) disable iff (!rstN)
    txDoneEvt |=> txStat); // R3
  AST_TX_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_TXSRC && !txDoneEvt) |=> !txStat); // R4
  AST_TX_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (txStat && !(rdEn && addr == ADDR_TXSRC)) |=> txStat); // R5
  AST_ALL_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (blkEn == '0) |-> !irqOut); // R7
  AST_RX_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (blkEn[BIT_RX_EN] && rxReq) |-> irqOut); // R8
  AST_SEC_SETS: assert property (@(posedge clk) disable iff (!rstN)
    secEvt |=> secStat); // R9
  AST_SEC_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (blkEn[BIT_SEC_EN] && secStat) |-> irqOut); // R9
  AST_BLK_ZEROS: assert property (@(posedge clk) disable iff (!rstN)
    $past(rdEn && addr == ADDR_BLK) |-> rdData[6:2] == '0); // R2
endmodule

bind irq_two_level irq_two_level_chk i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .addr      (addr),
  .rdEn      (rdEn),
  .rdData    (rdData),
  .txDoneEvt (txDoneEvt),
  .secEvt    (secEvt),
  .rxReq     (rxReq),
  .irqOut    (irqOut),
  .blkEn     (blkEn),
  .txStat    (txStat),
  .secStat   (secStat)
);

// File: tb/test_irq_two_level.sv
module test_irq_two_level;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wrData = '0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;
  logic       txDoneEvt = 1'b0;
  logic       secEvt = 1'b0;
  logic       rxReq = 1'b0;
  logic       irqOut;

  int nCompared = 0;
  int nFailed = 0;
  bit finished = 1'b0;

  logic [7:0] expQ[$];
  string      tagQ[$];

  always #10 clk = ~clk;

  irq_two_level i_irq_two_level (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .rdData(rdData), .txDoneEvt(txDoneEvt), .secEvt(secEvt),
    .rxReq(rxReq), .irqOut(irqOut)
  );

  // monitor: every read strobe seen at a rising edge yields one compare
  initial begin
    forever begin
      @(posedge clk);
      if (rdEn && rstN) begin
        @(negedge clk);
        if (expQ.size() == 0) begin
          nCompared++; nFailed++;
          $display("FAIL scoreboard: read with no expected item");
        end else begin
          logic [7:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          nCompared++;
          if (rdData !== e) begin
            nFailed++;
            $display("FAIL %s: rdData actual %02h expected %02h", t, rdData, e);
          end
        end
      end
    end
  end

  task automatic writeReg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [7:0] a, input logic [7:0] e, input string t,
                         input bit withEvt = 1'b0);
    @(negedge clk);
    addr = a; rdEn = 1'b1; txDoneEvt = withEvt;
    expQ.push_back(e); tagQ.push_back(t);
    @(negedge clk);
    rdEn = 1'b0; txDoneEvt = 1'b0;
  endtask

  task automatic pulseTx();
    @(negedge clk); txDoneEvt = 1'b1;
    @(negedge clk); txDoneEvt = 1'b0;
  endtask

  task automatic pulseSec();
    @(negedge clk); secEvt = 1'b1;
    @(negedge clk); secEvt = 1'b0;
  endtask

  task automatic checkIrq(input logic e, input string t);
    #2;
    nCompared++;
    if (irqOut !== e) begin
      nFailed++;
      $display("FAIL %s: irqOut actual %0b expected %0b", t, irqOut, e);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nFailed);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    nCompared++; nFailed++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkIrq(1'b0, "R1 irq after reset");
    readReg(8'h04, 8'h00, "R1 block enables");
    readReg(8'h34, 8'h00, "R1 tx source");
    readReg(8'h05, 8'h00, "R1 sec status");

    writeReg(8'h04, 8'hFF);
    readReg(8'h04, 8'h83, "R2 block readback");
    writeReg(8'h04, 8'h00);
    readReg(8'h04, 8'h00, "R2 block cleared");

    writeReg(8'h34, 8'hFF);
    readReg(8'h34, 8'h02, "R6 tx source readback");

    pulseTx();
    checkIrq(1'b0, "R7 block tx off");
    readReg(8'h34, 8'h03, "R3 status set");
    readReg(8'h34, 8'h02, "R4 status cleared");

    pulseTx();
    writeReg(8'h04, 8'h02);
    checkIrq(1'b1, "R7 both enables");
    writeReg(8'h34, 8'h00);
    checkIrq(1'b0, "R7 source off");
    readReg(8'h34, 8'h01, "R6 status survives cfg write");
    writeReg(8'h34, 8'h02);
    checkIrq(1'b0, "R4 cleared by read");
    pulseTx();
    checkIrq(1'b1, "R7 re-raised");
    readReg(8'h34, 8'h03, "R4 read returns set");
    checkIrq(1'b0, "R4 irq drops after read");

    readReg(8'h34, 8'h02, "R5 read with event returns old", 1'b1);
    checkIrq(1'b1, "R5 status kept");
    readReg(8'h34, 8'h03, "R5 status still set");

    writeReg(8'h04, 8'h00);
    @(negedge clk); rxReq = 1'b1;
    checkIrq(1'b0, "R8 rx gated off");
    writeReg(8'h04, 8'h80);
    checkIrq(1'b1, "R8 rx passes");
    @(negedge clk); rxReq = 1'b0;
    checkIrq(1'b0, "R8 rx dropped");

    writeReg(8'h04, 8'h00);
    pulseSec();
    checkIrq(1'b0, "R9 sec gated off");
    writeReg(8'h04, 8'h01);
    checkIrq(1'b1, "R9 sec passes");
    readReg(8'h05, 8'h01, "R9 sec status set");
    checkIrq(1'b0, "R9 sec cleared");
    readReg(8'h05, 8'h00, "R9 sec reads zero");

    writeReg(8'h10, 8'hFF);
    readReg(8'h10, 8'h00, "R10 unmapped read");
    readReg(8'h04, 8'h01, "R10 block untouched");
    readReg(8'h34, 8'h02, "R10 tx cfg untouched");

    repeat (2) @(negedge clk);
    if (expQ.size() != 0) begin
      nCompared++; nFailed++;
      $display("FAIL scoreboard: actual %0d left expected 0", expQ.size());
    end
    finish();
  end
endmodule